// File: doc/BRIEF.md
# Quarter-Rate Quadrature-to-Real Upconverter

This block turns a stream of complex baseband samples into a stream of real samples. It mixes each accepted sample with a local oscillator that runs at one quarter of the sample rate and keeps only the real part of the product. The oscillator steps through 1, j, -1 and -j, so each output is the in-phase word, the quadrature word, or the negation of one of them. No multiplier is needed. The upstream filter must oversample by two. The output then occupies twice the input bandwidth, and the two sidebands stay apart when the imaginary part is dropped.

One enable input chooses the mode. With the enable set, the block produces the mixed real stream. With the enable clear, both words pass through unchanged and the oscillator phase returns to its start. All words are two's complement. No gain is applied, because the oscillator has unit magnitude. Negation saturates, so the most negative input never wraps.

Top module: `uqr_upconv`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_vld is 0, and the oscillator phase is 0.
- R2: out_vld is 1 exactly one clock after a cycle with in_vld high, and 0 after a cycle with in_vld low.
- R3: With real_en = 0, an accepted sample gives out_i = in_i and out_q = in_q.
- R4: With real_en = 1, out_q = 0 and out_i follows the phase of the accepted sample. Phase 0 gives in_i, phase 1 gives -in_q, phase 2 gives -in_i and phase 3 gives in_q. The phase then wraps from 3 to 0.
- R5: The phase advances by one, modulo 4, only on a cycle with real_en = 1 and in_vld = 1. Idle cycles leave it unchanged.
- R6: Any cycle with real_en = 0 returns the phase to 0, whether or not a sample is present.
- R7: Negating the most negative value (-2^(W-1)) gives the most positive value (2^(W-1)-1).
- R8: On cycles without a valid output, out_i and out_q keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input sample accepted this cycle |
| real_en | input | 1 | 1 = mix to real, 0 = pass I/Q through |
| in_i | input | W | In-phase word, two's complement |
| in_q | input | W | Quadrature word, two's complement |
| out_vld | output | 1 | Output sample valid |
| out_i | output | W | Real sample, or the I word in pass-through mode |
| out_q | output | W | Q word in pass-through mode, 0 in real mode |

## Verification
The bench builds the block with W = 8. At this width the extremes -128 and 127 are easy to drive. Each one can be placed on every oscillator phase, so saturated negation on both the I and Q paths is exercised. The bench interleaves idle gaps and mode drops with real-mode samples. This checks that the phase moves only on accepted samples and restarts at 0 after the enable clears.

// File: rtl/uqr_pkg.sv
package uqr_pkg;
  localparam int PHASE_W = 2;

  // Phase of the quarter-rate oscillator: 1, j, -1, -j
  typedef enum logic [PHASE_W-1:0] {
    PH_POS_I = 2'd0,
    PH_NEG_Q = 2'd1,
    PH_NEG_I = 2'd2,
    PH_POS_Q = 2'd3
  } uqr_phase_t;
endpackage

// File: rtl/uqr_phase.sv
module uqr_phase
  import uqr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       clear,
  output uqr_phase_t phase
);
  logic [PHASE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase = uqr_phase_t'(cnt_q);
endmodule

// File: rtl/uqr_mix.sv
module uqr_mix
  import uqr_pkg::*;
#(
  parameter int W = 16
) (
  input  uqr_phase_t     phase,
  input  logic           real_en,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   a_q,
  output logic [W-1:0]   y_i,
  output logic [W-1:0]   y_q
);
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] neg_i, neg_q;

  // saturating negation: the one value without a positive twin clips
  assign neg_i = (a_i == MIN_V) ? MAX_V : (~a_i + 1'b1);
  assign neg_q = (a_q == MIN_V) ? MAX_V : (~a_q + 1'b1);

  always_comb begin
    y_i = a_i;
    y_q = a_q;
    if (real_en) begin
      y_q = '0;
      unique case (phase)
        PH_POS_I: y_i = a_i;
        PH_NEG_Q: y_i = neg_q;
        PH_NEG_I: y_i = neg_i;
        PH_POS_Q: y_i = a_q;
        default:  y_i = a_i;
      endcase
    end
  end
endmodule

// File: rtl/uqr_upconv.sv
module uqr_upconv
  import uqr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic         real_en,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] in_q,
  output logic         out_vld,
  output logic [W-1:0] out_i,
  output logic [W-1:0] out_q
);
  uqr_phase_t   ph_q;
  logic [W-1:0] mix_i, mix_q;

  uqr_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .step  (in_vld && real_en),
    .clear (!real_en),
    .phase (ph_q)
  );

  uqr_mix #(.W(W)) u_mix (
    .phase   (ph_q),
    .real_en (real_en),
    .a_i     (in_i),
    .a_q     (in_q),
    .y_i     (mix_i),
    .y_q     (mix_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_i   <= '0;
      out_q   <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_i <= mix_i;
        out_q <= mix_q;
      end
    end
  end
endmodule

// File: rtl/uqr_chk.sv
module uqr_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_vld,
  input logic         real_en,
  input logic [W-1:0] in_i,
  input logic [W-1:0] in_q,
  input logic         out_vld,
  input logic [W-1:0] out_i,
  input logic [W-1:0] out_q,
  input logic [1:0]   ph
);
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> (!out_vld && ph == 2'd0));

  assert_vld_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  assert_vld_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  assert_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !real_en) |=> (out_i == $past(in_i) && out_q == $past(in_q)));

  assert_real_q_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && real_en) |=> (out_q == '0));
  assert_real_ph0_R4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && real_en && ph == 2'd0) |=> (out_i == $past(in_i)));
  assert_real_ph3_R4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && real_en && ph == 2'd3) |=> (out_i == $past(in_q)));

  assert_ph_step_R5: assert property (@(posedge clk) disable iff (rst)
    (in_vld && real_en) |=> (ph == $past(ph) + 2'd1));
  assert_ph_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && real_en) |=> (ph == $past(ph)));

  assert_ph_clear_R6: assert property (@(posedge clk) disable iff (rst)
    !real_en |=> (ph == 2'd0));

  assert_sat_i_R7: assert property (@(posedge clk) disable iff (rst)
    (in_vld && real_en && ph == 2'd2 && in_i == MIN_V) |=> (out_i == MAX_V));
  assert_sat_q_R7: assert property (@(posedge clk) disable iff (rst)
    (in_vld && real_en && ph == 2'd1 && in_q == MIN_V) |=> (out_i == MAX_V));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(out_i) && $stable(out_q)));
endmodule

bind uqr_upconv uqr_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .real_en (real_en),
  .in_i    (in_i),
  .in_q    (in_q),
  .out_vld (out_vld),
  .out_i   (out_i),
  .out_q   (out_q),
  .ph      (ph_q)
);

// File: tb/sim_uqr_upconv.sv
`timescale 1ns/100ps
module sim_uqr_upconv;
  localparam int W = 8;
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic real_en = 1'b0;
  logic [W-1:0] in_i = '0, in_q = '0;
  logic out_vld;
  logic [W-1:0] out_i, out_q;

  always #2.5 clk = ~clk;

  uqr_upconv #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .real_en(real_en),
    .in_i(in_i), .in_q(in_q), .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int mph     = 0;
  logic [2*W-1:0] sb_q[$];
  string          sb_tag[$];
  logic [W-1:0]   last_i = '0, last_q = '0;

  function automatic logic [W-1:0] sneg(input logic [W-1:0] x);
    return (x == MIN_V) ? MAX_V : (~x + 1'b1);
  endfunction

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic en, input string tag);
    logic [W-1:0] ei, eq;
    @(negedge clk);
    in_vld = 1'b1; real_en = en; in_i = a; in_q = b;
    if (!en) begin
      ei = a; eq = b; mph = 0;
    end else begin
      eq = '0;
      case (mph)
        0: ei = a;
        1: ei = sneg(b);
        2: ei = sneg(a);
        default: ei = b;
      endcase
      mph = (mph + 1) % 4;
    end
    sb_q.push_back({ei, eq});
    sb_tag.push_back(tag);
  endtask

  task automatic idle(input logic en, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_vld = 1'b0; real_en = en;
      if (!en) mph = 0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      last_i = '0; last_q = '0;
    end else if (out_vld) begin
      n_tests++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected out_vld: got %0h/%0h expected no sample", out_i, out_q);
      end else begin
        logic [2*W-1:0] e;
        string t;
        e = sb_q.pop_front();
        t = sb_tag.pop_front();
        if ({out_i, out_q} !== e) begin
          n_fail++;
          $display("FAIL %s: got i=%0h q=%0h expected i=%0h q=%0h",
                   t, out_i, out_q, e[2*W-1:W], e[W-1:0]);
        end
      end
      last_i = out_i; last_q = out_q;
    end else begin
      n_tests++;
      if (out_i !== last_i || out_q !== last_q) begin
        n_fail++;
        $display("FAIL R8 hold: got %0h/%0h expected %0h/%0h", out_i, out_q, last_i, last_q);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got no finish, expected end of run");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_vld !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got out_vld=%b expected 0", out_vld);
    end
    rst = 1'b0;
    n_tests++;
    @(negedge clk);
    if (out_vld !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 after reset: got out_vld=%b expected 0", out_vld);
    end

    // R3 pass-through
    send(8'h05, 8'hFD, 1'b0, "R3");
    send(MIN_V, MAX_V, 1'b0, "R3");
    idle(1'b0, 2);

    // R4 two full periods, back to back
    for (int k = 0; k < 8; k++)
      send(8'(k * 13 + 3), 8'(k * 29 - 40), 1'b1, "R4");

    // R5 idle gaps between real samples
    send(8'h11, 8'h22, 1'b1, "R5");
    idle(1'b1, 3);
    send(8'h33, 8'h44, 1'b1, "R5");
    idle(1'b1, 1);
    send(8'h55, 8'h66, 1'b1, "R5");

    // R6 enable drop without a sample restarts the phase
    idle(1'b0, 1);
    send(8'h70, 8'h07, 1'b1, "R6");
    send(8'h10, 8'h20, 1'b1, "R6");
    // R6 a pass-through sample in the middle
    send(8'h01, 8'h02, 1'b0, "R6");
    send(8'h30, 8'h40, 1'b1, "R6");

    // R7 extremes on every phase
    idle(1'b0, 1);
    send(MIN_V, MIN_V, 1'b1, "R7");
    send(MIN_V, MIN_V, 1'b1, "R7");
    send(MIN_V, MIN_V, 1'b1, "R7");
    send(MIN_V, MIN_V, 1'b1, "R7");
    send(MAX_V, MAX_V, 1'b1, "R7");
    send(MAX_V, MAX_V, 1'b1, "R7");
    send(MAX_V, MAX_V, 1'b1, "R7");

    idle(1'b1, 4);
    n_tests++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing outputs: got %0d pending expected 0", sb_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule